// File: doc/BRIEF.md
# Trailing-Bit Mask and Field-Extract Unit

This execution unit serves a processor's bit-manipulation instruction group. It accepts one 64-bit source operand, a 4-bit operation code and a 16-bit control word. The control word matters only for the field-extract operation, which pulls a right-aligned, zero-extended bit field out of the source. The other nine operations build masks around the lowest clear bit or the lowest set bit of the source. Each of these nine adds one to the source or subtracts one from it, then combines that value with the source or with its complement.

Every operation writes a 64-bit result and a flag set: CF, ZF, SF, OF, PF and AF. The interface is one registered stage. When `in_valid` is high, the operands are taken in, and the result, the flags and `out_valid` appear after the next rising clock edge. Operation codes that are not assigned raise `out_illegal`, give a zero result and leave every flag clear.

Top module: `tbm_unit`

## Requirements
- R1: `out_valid` equals the value `in_valid` had at the previous rising edge. A synchronous active-low reset clears `out_valid`, `out_result`, every flag and `out_illegal`.
- R2: Code 0 is the field extract. It reads the start position from control bits [7:0] and the length from control bits [15:8]. It returns source bits start..start+length-1 at result bits 0..length-1, and every other result bit is zero.
- R3: In the field extract, a start of 64 or more gives zero and a length of 0 gives zero. A length that runs past bit 63 returns only the source bits that exist, up to bit 63.
- R4: With x the source, codes 1 to 6 give, in order: (x+1)&x, ~(x+1)|x, (x+1)&~x, (x+1)^x, (x+1)|x, (x+1)|~x.
- R5: Codes 7, 8 and 9 give (x-1)|x, (x-1)|~x and (x-1)&~x respectively.
- R6: For codes 1 to 6, CF is 1 exactly when the source is all ones, that is, when x+1 wraps to zero.
- R7: For codes 7 to 9, CF is 1 exactly when the source is zero.
- R8: For codes 0 to 9, ZF is 1 when the result is zero, SF is result bit 63, and PF is 1 when result bits [7:0] hold an even number of ones. OF and AF are always 0. For code 0, CF is 0.
- R9: Codes 10 to 15 give a zero result, CF, ZF, SF, OF, PF and AF all 0, and `out_illegal` 1. For codes 0 to 9, `out_illegal` is 0.
- R10: While `in_valid` is low, `out_result`, the flags and `out_illegal` keep their values, whatever changes on the operand inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | The operands on this cycle are to be executed |
| in_src | input | 64 | Source operand |
| in_op | input | 4 | Operation code, 0 to 9 assigned |
| in_ctrl | input | 16 | Field-extract control: start in [7:0], length in [15:8] |
| out_valid | output | 1 | The result registers hold a new result |
| out_result | output | 64 | Operation result |
| out_cf | output | 1 | Carry flag |
| out_zf | output | 1 | Zero flag |
| out_sf | output | 1 | Sign flag |
| out_of | output | 1 | Overflow flag, always 0 |
| out_pf | output | 1 | Parity flag over result bits [7:0] |
| out_af | output | 1 | Adjust flag, always 0 |
| out_illegal | output | 1 | The operation code was not assigned |

## Verification
The assertions assume that `in_src`, `in_op` and `in_ctrl` are stable and known at every rising edge where `in_valid` is high. They also assume that reset is asserted at the first edge, so every past value they compare lies after reset. The bench changes inputs only at falling edges and holds reset through the first cycles, which keeps it within both assumptions. The random operands include all-ones, zero and runs of trailing ones or zeros, and the random control words include starts beyond bit 63 and lengths of zero and past the top. This keeps every carry and clipping rule exercised in addition to ordinary operands.

// File: rtl/tbm_pkg.sv
// Shared types for the trailing-bit mask unit.
// Assumes a 4-bit operation code; codes above OP_MSK_ZEROS are unassigned.
package tbm_pkg;

    typedef enum logic [3:0] {
        OP_FIELD       = 4'd0,
        OP_FILL_LOWCLR = 4'd1,
        OP_ISOCLR_INV  = 4'd2,
        OP_ISOCLR      = 4'd3,
        OP_MSK_LOWCLR  = 4'd4,
        OP_SET_LOWCLR  = 4'd5,
        OP_INVMSK_ONES = 4'd6,
        OP_FILL_LOWSET = 4'd7,
        OP_ISOSET_CMP  = 4'd8,
        OP_MSK_ZEROS   = 4'd9
    } tbm_op_e;

    typedef struct packed {
        logic cf;
        logic zf;
        logic sf;
        logic ovf;
        logic pf;
        logic af;
    } tbm_flags_t;

    // True for codes that build their mask from source plus one
    function automatic logic op_uses_inc(input logic [3:0] op);
        return (op >= 4'd1) && (op <= 4'd6);
    endfunction

    // True for codes that build their mask from source minus one
    function automatic logic op_uses_dec(input logic [3:0] op);
        return (op >= 4'd7) && (op <= 4'd9);
    endfunction

endpackage

// File: rtl/tbm_field_extract.sv
// Right-aligned bit-field extraction.
// The control word carries the start position in its low FIELD_W bits and
// the length in its high FIELD_W bits. Out-of-range starts give zero, and
// over-long lengths are clipped by the shift, which zero-fills from the top.
module tbm_field_extract #(
    parameter int WIDTH   = 64,
    parameter int FIELD_W = 8
) (
    input  logic [WIDTH-1:0]     src,
    input  logic [2*FIELD_W-1:0] ctrl,
    output logic [WIDTH-1:0]     result
);
    logic [FIELD_W-1:0] start_pos;
    logic [FIELD_W-1:0] field_len;
    logic [WIDTH-1:0]   shifted;
    logic [WIDTH-1:0]   len_mask;

    assign start_pos = ctrl[FIELD_W-1:0];
    assign field_len = ctrl[2*FIELD_W-1:FIELD_W];

    // Move the field down to bit 0, or give zero if the start lies past the top
    always_comb begin
        if (32'(start_pos) >= WIDTH) shifted = '0;
        else                         shifted = src >> start_pos;
    end

    // One comparator per bit keeps the low `field_len` bits
    for (genvar i = 0; i < WIDTH; i++) begin : g_len_mask
        assign len_mask[i] = (32'(field_len) > i);
    end

    assign result = shifted & len_mask;
endmodule

// File: rtl/tbm_mask_gen.sv
// The nine mask operations built on source +/- 1.
// The carry comes from the adder's own extra bit: the carry out of x+1, or
// the borrow out of x-1. No separate all-ones or zero compare is used.
module tbm_mask_gen
    import tbm_pkg::*;
#(
    parameter int WIDTH = 64
) (
    input  logic [WIDTH-1:0] src,
    input  logic [3:0]       op,
    output logic [WIDTH-1:0] mask,
    output logic             carry
);
    logic [WIDTH:0] inc_full;
    logic [WIDTH:0] dec_full;
    logic [WIDTH-1:0] inc_v;
    logic [WIDTH-1:0] dec_v;

    assign inc_full = {1'b0, src} + {{WIDTH{1'b0}}, 1'b1};
    assign dec_full = {1'b0, src} - {{WIDTH{1'b0}}, 1'b1};
    assign inc_v    = inc_full[WIDTH-1:0];
    assign dec_v    = dec_full[WIDTH-1:0];

    // Pick the mask formula for the current code
    always_comb begin
        case (tbm_op_e'(op))
            OP_FILL_LOWCLR: mask = inc_v & src;
            OP_ISOCLR_INV:  mask = ~inc_v | src;
            OP_ISOCLR:      mask = inc_v & ~src;
            OP_MSK_LOWCLR:  mask = inc_v ^ src;
            OP_SET_LOWCLR:  mask = inc_v | src;
            OP_INVMSK_ONES: mask = inc_v | ~src;
            OP_FILL_LOWSET: mask = dec_v | src;
            OP_ISOSET_CMP:  mask = dec_v | ~src;
            OP_MSK_ZEROS:   mask = dec_v & ~src;
            default:        mask = '0;
        endcase
    end

    // Carry out of the increment, or borrow out of the decrement
    always_comb begin
        if (op_uses_inc(op))      carry = inc_full[WIDTH];
        else if (op_uses_dec(op)) carry = dec_full[WIDTH];
        else                      carry = 1'b0;
    end
endmodule

// File: rtl/tbm_flag_gen.sv
// Flags under the logic-instruction convention, taken from the final result.
// Assumes `carry_in` is already forced to zero for codes that clear CF.
// An illegal code clears every flag.
module tbm_flag_gen
    import tbm_pkg::*;
#(
    parameter int WIDTH = 64
) (
    input  logic [WIDTH-1:0] result,
    input  logic             carry_in,
    input  logic             legal,
    output tbm_flags_t       flags
);
    // Form the flags, or give all zero for an unassigned code
    always_comb begin
        flags = '0;
        if (legal) begin
            flags.cf  = carry_in;
            flags.zf  = (result == '0);
            flags.sf  = result[WIDTH-1];
            flags.pf  = ~^result[7:0];
            flags.ovf = 1'b0;
            flags.af  = 1'b0;
        end
    end
endmodule

// File: rtl/tbm_unit.sv
// Top level of the trailing-bit mask and field-extract unit.
// There is one register stage. The operands are taken when in_valid is
// high, and the results hold their value otherwise. Reset is synchronous
// and active low.
module tbm_unit
    import tbm_pkg::*;
#(
    parameter int WIDTH   = 64,
    parameter int OP_W    = 4,
    parameter int FIELD_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [WIDTH-1:0]     in_src,
    input  logic [OP_W-1:0]      in_op,
    input  logic [2*FIELD_W-1:0] in_ctrl,
    output logic                 out_valid,
    output logic [WIDTH-1:0]     out_result,
    output logic                 out_cf,
    output logic                 out_zf,
    output logic                 out_sf,
    output logic                 out_of,
    output logic                 out_pf,
    output logic                 out_af,
    output logic                 out_illegal
);
    localparam int LAST_CODE = 9;

    logic [WIDTH-1:0] field_res;
    logic [WIDTH-1:0] mask_res;
    logic             mask_carry;
    logic             legal;
    logic             is_field;
    logic [WIDTH-1:0] next_result;
    logic             next_carry;
    tbm_flags_t       next_flags;

    assign legal    = (32'(in_op) <= LAST_CODE);
    assign is_field = (in_op == OP_W'(OP_FIELD));

    tbm_field_extract #(.WIDTH(WIDTH), .FIELD_W(FIELD_W)) u_field (
        .src    (in_src),
        .ctrl   (in_ctrl),
        .result (field_res)
    );

    tbm_mask_gen #(.WIDTH(WIDTH)) u_mask (
        .src   (in_src),
        .op    (4'(in_op)),
        .mask  (mask_res),
        .carry (mask_carry)
    );

    // Choose the result and the carry source for the code
    always_comb begin
        if (!legal)        begin next_result = '0;        next_carry = 1'b0;       end
        else if (is_field) begin next_result = field_res; next_carry = 1'b0;       end
        else               begin next_result = mask_res;  next_carry = mask_carry; end
    end

    tbm_flag_gen #(.WIDTH(WIDTH)) u_flags (
        .result   (next_result),
        .carry_in (next_carry),
        .legal    (legal),
        .flags    (next_flags)
    );

    // Output stage: valid follows the input, and the data loads only on a valid input
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_result  <= '0;
            out_cf      <= 1'b0;
            out_zf      <= 1'b0;
            out_sf      <= 1'b0;
            out_of      <= 1'b0;
            out_pf      <= 1'b0;
            out_af      <= 1'b0;
            out_illegal <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_result  <= next_result;
                out_cf      <= next_flags.cf;
                out_zf      <= next_flags.zf;
                out_sf      <= next_flags.sf;
                out_of      <= next_flags.ovf;
                out_pf      <= next_flags.pf;
                out_af      <= next_flags.af;
                out_illegal <= ~legal;
            end
        end
    end
endmodule

// File: rtl/tbm_unit_chk.sv
// Property checker for tbm_unit, attached to it by bind.
// Assumes reset is asserted at the first clock edge.
module tbm_unit_chk #(
    parameter int WIDTH   = 64,
    parameter int OP_W    = 4,
    parameter int FIELD_W = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic [WIDTH-1:0]     in_src,
    input logic [OP_W-1:0]      in_op,
    input logic [2*FIELD_W-1:0] in_ctrl,
    input logic                 out_valid,
    input logic [WIDTH-1:0]     out_result,
    input logic                 out_cf,
    input logic                 out_zf,
    input logic                 out_sf,
    input logic                 out_of,
    input logic                 out_pf,
    input logic                 out_af,
    input logic                 out_illegal
);
    p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(in_valid)));

    p_far_start_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == '0 && 32'(in_ctrl[FIELD_W-1:0]) >= WIDTH)
        |=> (out_result == '0 && out_zf && !out_cf));

    p_inc_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op >= OP_W'(1) && in_op <= OP_W'(6))
        |=> (out_cf == (&$past(in_src))));

    p_dec_carry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op >= OP_W'(7) && in_op <= OP_W'(9))
        |=> (out_cf == ($past(in_src) == '0)));

    p_of_af_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_of && !out_af));

    p_zf_sf_pf_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_illegal) |->
        (out_zf == (out_result == '0) && out_sf == out_result[WIDTH-1]
         && out_pf == ~^out_result[7:0]));

    p_illegal_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_illegal |-> (out_result == '0 && !out_cf && !out_zf && !out_sf && !out_pf));

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(in_valid)) |->
        ($stable(out_result) && $stable(out_cf) && $stable(out_zf) && $stable(out_illegal)));
endmodule

bind tbm_unit tbm_unit_chk #(.WIDTH(WIDTH), .OP_W(OP_W), .FIELD_W(FIELD_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_src      (in_src),
    .in_op       (in_op),
    .in_ctrl     (in_ctrl),
    .out_valid   (out_valid),
    .out_result  (out_result),
    .out_cf      (out_cf),
    .out_zf      (out_zf),
    .out_sf      (out_sf),
    .out_of      (out_of),
    .out_pf      (out_pf),
    .out_af      (out_af),
    .out_illegal (out_illegal)
);

// File: tb/sim_tbm_unit.sv
`timescale 1ns/1ps
module sim_tbm_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_src = '0;
    logic [3:0]  in_op = '0;
    logic [15:0] in_ctrl = '0;
    logic        out_valid, out_cf, out_zf, out_sf, out_of, out_pf, out_af, out_illegal;
    logic [63:0] out_result;

    int checks = 0;
    int errors = 0;
    logic [63:0] last_res;

    always #4 clk = ~clk;

    tbm_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_src(in_src),
        .in_op(in_op), .in_ctrl(in_ctrl), .out_valid(out_valid),
        .out_result(out_result), .out_cf(out_cf), .out_zf(out_zf),
        .out_sf(out_sf), .out_of(out_of), .out_pf(out_pf), .out_af(out_af),
        .out_illegal(out_illegal)
    );

    function automatic logic [63:0] ref_result(logic [63:0] x, logic [3:0] op, logic [15:0] c);
        logic [63:0] r = '0;
        int s = int'(c[7:0]);
        int l = int'(c[15:8]);
        case (op)
            4'd0: for (int k = 0; k < l; k++) if (s + k < 64) r[k] = x[s + k];
            4'd1: r = (x + 64'd1) & x;
            4'd2: r = ~(x + 64'd1) | x;
            4'd3: r = (x + 64'd1) & ~x;
            4'd4: r = (x + 64'd1) ^ x;
            4'd5: r = (x + 64'd1) | x;
            4'd6: r = (x + 64'd1) | ~x;
            4'd7: r = (x - 64'd1) | x;
            4'd8: r = (x - 64'd1) | ~x;
            4'd9: r = (x - 64'd1) & ~x;
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic logic ref_cf(logic [63:0] x, logic [3:0] op);
        if (op >= 4'd1 && op <= 4'd6) return (x == '1);
        if (op >= 4'd7 && op <= 4'd9) return (x == '0);
        return 1'b0;
    endfunction

    task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one operation, then check it at the next falling edge
    task automatic run_op(input logic [63:0] x, input logic [3:0] op, input logic [15:0] c, input string rtag);
        logic [63:0] er;
        logic ecf, ezf, esf, epf, eill;
        string t;
        @(negedge clk);
        in_valid = 1'b1; in_src = x; in_op = op; in_ctrl = c;
        er   = ref_result(x, op, c);
        eill = (op > 4'd9);
        ecf  = ref_cf(x, op);
        ezf  = !eill && (er == '0);
        esf  = !eill && er[63];
        epf  = !eill && ~^er[7:0];
        @(negedge clk);
        if (rtag != "") t = rtag;
        else if (op == 4'd0) t = "R2";
        else if (op <= 4'd6) t = "R4";
        else if (op <= 4'd9) t = "R5";
        else t = "R9";
        check(out_valid == 1'b1, "R1 valid", 64'(out_valid), 64'd1);
        check(out_result == er, t, out_result, er);
        check(out_cf == ecf, (op >= 1 && op <= 6) ? "R6 cf" : (op >= 7 && op <= 9) ? "R7 cf" : "R8 cf",
              64'(out_cf), 64'(ecf));
        check({out_zf, out_sf, out_pf} == {ezf, esf, epf}, eill ? "R9 flags" : "R8 zf/sf/pf",
              64'({out_zf, out_sf, out_pf}), 64'({ezf, esf, epf}));
        check(!out_of && !out_af, "R8 of/af", 64'({out_of, out_af}), 64'd0);
        check(out_illegal == eill, "R9 illegal", 64'(out_illegal), 64'(eill));
        last_res = er;
    endtask

    function automatic logic [63:0] pick_src();
        case ($urandom_range(0, 5))
            0: return '1;
            1: return '0;
            2: return (64'd1 << $urandom_range(0, 63)) - 64'd1;
            3: return ~((64'd1 << $urandom_range(0, 63)) - 64'd1);
            default: return {$urandom, $urandom};
        endcase
    endfunction

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20251));
        in_valid = 1'b1; in_src = '1; in_op = 4'd5;
        repeat (3) @(negedge clk);
        // R1: reset clears every output
        check(out_valid == 1'b0 && out_result == '0 && !out_cf && !out_zf && !out_illegal,
              "R1 reset", out_result, 64'd0);
        rst_n = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 idle", 64'(out_valid), 64'd0);

        // R2 and R3: directed field-extract cases
        run_op(64'hFEDC_BA98_7654_3210, 4'd0, {8'd8, 8'd4}, "R2");
        run_op(64'hFEDC_BA98_7654_3210, 4'd0, {8'd16, 8'd64}, "R3 start64");
        run_op(64'hFEDC_BA98_7654_3210, 4'd0, {8'd0, 8'd3}, "R3 len0");
        run_op(64'hFEDC_BA98_7654_3210, 4'd0, {8'd200, 8'd60}, "R3 clip");
        run_op(64'h8000_0000_0000_0000, 4'd0, {8'd1, 8'd63}, "R3 topbit");
        // R6 and R7: carry corners
        for (int op = 1; op <= 6; op++) run_op('1, 4'(op), 16'h0, "R6 ones");
        for (int op = 7; op <= 9; op++) run_op('0, 4'(op), 16'h0, "R7 zero");
        run_op(64'h0000_0000_0000_00A7, 4'd3, 16'h0, "R4");
        run_op(64'h0000_0000_0000_0058, 4'd9, 16'h0, "R5");
        // R9: every unassigned code
        for (int op = 10; op <= 15; op++) run_op(64'h1234, 4'(op), 16'hFFFF, "R9");

        // R10: outputs hold while in_valid is low
        @(negedge clk);
        in_valid = 1'b0; in_src = 64'h5555; in_op = 4'd4; in_ctrl = 16'h0101;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 drop", 64'(out_valid), 64'd0);
        @(negedge clk);
        check(out_result == last_res && out_illegal == 1'b1, "R10 hold", out_result, last_res);

        // Random mix across all codes
        for (int n = 0; n < 3000; n++) begin
            logic [15:0] c;
            c[7:0]  = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'($urandom_range(0, 63));
            c[15:8] = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'($urandom_range(0, 64));
            run_op(pick_src(), 4'($urandom_range(0, 15)), c, "");
        end

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule